// File: doc/BRIEF.md
# Three-Bus Register File with Instruction-Driven Selectors

This block holds the general-purpose registers of a small 32-bit processor datapath. It has eight 32-bit entries and three buses: two read buses (B1 and B2) that feed the ALU and the address path, and one write bus (B3) that carries results back. The block does not take register numbers from a controller. Instead, it slices them straight out of the current instruction word. The controller supplies only three transfer enables, one per bus.

Entry 0 is hard-wired to zero. This lets the same index path serve both direct and indexed memory references. The block also forms a memory address by adding the zero-extended 20-bit address field of the instruction to the register named in the index field.

In almost every instruction the B1 selector comes from the third register field. The one exception is the store-register opcode. There, the B1 selector is taken from the destination field, because that field names the data source.

Top module: `trip_bus_regfile`

## Requirements
- R1: `sel_b3` always equals `instr[25:23]` and `sel_b2` always equals `instr[22:20]`, combinationally from `instr`.
- R2: `sel_b1` equals `instr[25:23]` when `instr[31:27]` is 5'b01101 (store register). For every other opcode it equals `instr[19:17]`.
- R3: When `en_b1` is 1, `bus_b1` shows the contents of the register numbered by `sel_b1`. When `en_b1` is 0, `bus_b1` is all zeros.
- R4: When `en_b2` is 1, `bus_b2` shows the contents of the register numbered by `sel_b2`. When `en_b2` is 0, `bus_b2` is all zeros.
- R5: On a rising clock edge with `en_b3` at 1 and reset low, the register numbered by `sel_b3` takes the value of `bus_b3`. No register changes on an edge where `en_b3` is 0. The new value is visible on the read buses in the cycle after the edge.
- R6: Register 0 reads as zero on every port. A write aimed at register 0 is ignored.
- R7: `mem_addr` equals `{12'b0, instr[19:0]}` plus the contents of the register numbered by `instr[22:20]`, truncated to 32 bits. An index of 0 therefore yields the address field alone.
- R8: A rising edge with `rst` at 1 clears registers 1 to 7 to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Current instruction word |
| en_b1 | input | 1 | Drive the selected register onto B1 |
| en_b2 | input | 1 | Drive the selected register onto B2 |
| en_b3 | input | 1 | Write B3 into the selected register |
| bus_b3 | input | 32 | Write data bus |
| bus_b1 | output | 32 | Read bus 1 |
| bus_b2 | output | 32 | Read bus 2 |
| sel_b1 | output | 3 | Register number used for B1 |
| sel_b2 | output | 3 | Register number used for B2 |
| sel_b3 | output | 3 | Register number used for B3 |
| mem_addr | output | 32 | Address field plus index register |

## Verification
The read paths are combinational, so a corrupted register shows up in the very next cycle in which any bus or the address output names that entry. The bench reads every entry through B1, B2 and the index path from randomly drawn instruction words. A wrong or missed write, a stray write to entry 0, or an incomplete reset therefore surfaces within one cycle of the first such read. Selector errors, including a mis-decoded store opcode, show up on the same cycle the instruction is presented.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  parameter int DATA_W    = 32;
  parameter int NUM_REGS  = 8;
  parameter int IR_W      = 32;
  parameter int AFIELD_W  = 20;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int OPC_W    = 5;
  localparam int OPC_LO   = IR_W - OPC_W;
  localparam int DST_LO   = 23;
  localparam int IDX_LO   = 20;
  localparam int SR1_LO   = 17;
  localparam logic [OPC_W-1:0] OPC_STORE = 5'b01101;

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    sel_t rd1;
    sel_t rd2;
    sel_t wr;
  } sel_bundle_t;
endpackage

// File: rtl/regbus_sel_decode.sv
module regbus_sel_decode
  import regbus_pkg::*;
(
  input  logic [IR_W-1:0] instr,
  output sel_bundle_t     sels
);
  logic [OPC_W-1:0] opc;
  logic             is_store;

  always_comb begin
    opc      = instr[OPC_LO +: OPC_W];
    is_store = (opc == OPC_STORE);
    sels.wr  = instr[DST_LO +: SEL_W];
    sels.rd2 = instr[IDX_LO +: SEL_W];
    sels.rd1 = is_store ? instr[DST_LO +: SEL_W] : instr[SR1_LO +: SEL_W];
  end
endmodule

// File: rtl/regbus_array.sv
module regbus_array
  import regbus_pkg::*;
#(
  parameter int N_RD = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  sel_t            waddr,
  input  word_t           wdata,
  input  sel_t [N_RD-1:0] raddr,
  output word_t [N_RD-1:0] rdata
);
  word_t store [1:NUM_REGS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < NUM_REGS; i++) store[i] <= '0;
    end else if (we && waddr != '0) begin
      store[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0) rdata[p] = '0;
      else                rdata[p] = store[raddr[p]];
    end
  end
endmodule

// File: rtl/regbus_addr_gen.sv
module regbus_addr_gen
  import regbus_pkg::*;
(
  input  logic [AFIELD_W-1:0] field,
  input  word_t               index_val,
  output word_t               addr
);
  always_comb addr = {{(DATA_W-AFIELD_W){1'b0}}, field} + index_val;
endmodule

// File: rtl/trip_bus_regfile.sv
module trip_bus_regfile
  import regbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IR_W-1:0]   instr,
  input  logic              en_b1,
  input  logic              en_b2,
  input  logic              en_b3,
  input  logic [DATA_W-1:0] bus_b3,
  output logic [DATA_W-1:0] bus_b1,
  output logic [DATA_W-1:0] bus_b2,
  output logic [SEL_W-1:0]  sel_b1,
  output logic [SEL_W-1:0]  sel_b2,
  output logic [SEL_W-1:0]  sel_b3,
  output logic [DATA_W-1:0] mem_addr
);
  localparam int PORT_B1 = 0;
  localparam int PORT_B2 = 1;
  localparam int PORT_IX = 2;

  sel_bundle_t     sels;
  sel_t  [2:0]     raddr;
  word_t [2:0]     rdata;

  regbus_sel_decode u_dec (.instr(instr), .sels(sels));

  always_comb begin
    raddr[PORT_B1] = sels.rd1;
    raddr[PORT_B2] = sels.rd2;
    raddr[PORT_IX] = instr[IDX_LO +: SEL_W];
  end

  regbus_array #(.N_RD(3)) u_arr (
    .clk(clk), .rst(rst), .we(en_b3), .waddr(sels.wr), .wdata(bus_b3),
    .raddr(raddr), .rdata(rdata)
  );

  regbus_addr_gen u_agen (
    .field(instr[AFIELD_W-1:0]), .index_val(rdata[PORT_IX]), .addr(mem_addr)
  );

  always_comb begin
    bus_b1 = en_b1 ? rdata[PORT_B1] : '0;
    bus_b2 = en_b2 ? rdata[PORT_B2] : '0;
    sel_b1 = sels.rd1;
    sel_b2 = sels.rd2;
    sel_b3 = sels.wr;
  end
endmodule

// File: rtl/regbus_chk.sv
module regbus_chk
  import regbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IR_W-1:0]   instr,
  input  logic              en_b1,
  input  logic              en_b2,
  input  logic              en_b3,
  input  logic [DATA_W-1:0] bus_b3,
  input  logic [DATA_W-1:0] bus_b1,
  input  logic [DATA_W-1:0] bus_b2,
  input  logic [SEL_W-1:0]  sel_b1,
  input  logic [SEL_W-1:0]  sel_b2,
  input  logic [SEL_W-1:0]  sel_b3,
  input  logic [DATA_W-1:0] mem_addr
);
  p_store_sel_r2: assert property (@(posedge clk) disable iff (rst)
    (instr[31:27] == 5'b01101) |-> (sel_b1 == instr[25:23]));
  p_b1_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !en_b1 |-> (bus_b1 == '0));
  p_b2_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !en_b2 |-> (bus_b2 == '0));
  p_wr_then_rd_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en_b3) && $past(sel_b3) != '0 && en_b2 &&
     sel_b2 == $past(sel_b3)) |-> (bus_b2 == $past(bus_b3)));
  p_zero_reg_r6: assert property (@(posedge clk) disable iff (rst)
    (en_b1 && sel_b1 == '0) |-> (bus_b1 == '0));
  p_direct_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (instr[22:20] == 3'd0) |-> (mem_addr == {{(DATA_W-AFIELD_W){1'b0}}, instr[AFIELD_W-1:0]}));
  p_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && en_b2) |-> (bus_b2 == '0));
  p_sel_b3_r1: assert property (@(posedge clk) disable iff (rst)
    (sel_b3 == instr[25:23]) && (sel_b2 == instr[22:20]));
endmodule

bind trip_bus_regfile regbus_chk u_chk (.*);

// File: tb/trip_bus_regfile_bench.sv
module trip_bus_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        en_b1 = 1'b0, en_b2 = 1'b0, en_b3 = 1'b0;
  logic [31:0] bus_b3 = '0;
  logic [31:0] bus_b1, bus_b2, mem_addr;
  logic [2:0]  sel_b1, sel_b2, sel_b3;

  int n_chk = 0;
  int n_fail = 0;
  bit checking = 1'b0;
  logic [31:0] mdl [8];

  always #5 clk = ~clk;

  trip_bus_regfile u_trip_bus_regfile (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: register contents updated on each rising edge
  initial for (int i = 0; i < 8; i++) mdl[i] = '0;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < 8; i++) mdl[i] = '0;
    end else if (en_b3 && instr[25:23] != 3'd0) begin
      mdl[instr[25:23]] = bus_b3;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      logic [2:0] e1;
      e1 = (instr[31:27] == 5'b01101) ? instr[25:23] : instr[19:17];
      chk("R1 sel_b3", {29'd0, sel_b3}, {29'd0, instr[25:23]});
      chk("R1 sel_b2", {29'd0, sel_b2}, {29'd0, instr[22:20]});
      chk("R2 sel_b1", {29'd0, sel_b1}, {29'd0, e1});
      chk("R3/R6 bus_b1", bus_b1, en_b1 ? mdl[e1] : 32'd0);
      chk("R4/R6 bus_b2", bus_b2, en_b2 ? mdl[instr[22:20]] : 32'd0);
      chk("R7 mem_addr", mem_addr, {12'd0, instr[19:0]} + mdl[instr[22:20]]);
    end
  end

  task automatic step(input logic [31:0] ir, input logic e1, input logic e2,
                      input logic e3, input logic [31:0] wd);
    @(posedge clk); #1;
    instr = ir; en_b1 = e1; en_b2 = e2; en_b3 = e3; bus_b3 = wd;
  endtask

  function automatic logic [31:0] mk(input logic [4:0] op, input logic [2:0] d,
                                     input logic [2:0] s2, input logic [2:0] s1,
                                     input logic [16:0] lo);
    return {op, 1'b0, d, s2, s1, lo};
  endfunction

  initial begin
    fork
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        checking = 1'b1;
        // R8: reset state, every entry reads zero on B2
        for (int r = 0; r < 8; r++) begin
          step(mk(5'b10101, 3'd0, 3'(r), 3'd0, 17'd0), 1'b0, 1'b1, 1'b0, '0);
          #4 chk("R8 reset value", bus_b2, 32'd0);
        end
        // R5: fill registers 1..7
        for (int r = 1; r < 8; r++)
          step(mk(5'b00001, 3'(r), 3'd0, 3'd0, 17'd0), 1'b0, 1'b0, 1'b1, 32'hA0000000 + r * 32'h1111);
        // R6: attempt to write register 0
        step(mk(5'b00001, 3'd0, 3'd0, 3'd0, 17'd0), 1'b0, 1'b0, 1'b1, 32'hDEADBEEF);
        step(mk(5'b10101, 3'd0, 3'd0, 3'd0, 17'd0), 1'b1, 1'b1, 1'b0, '0);
        #4 chk("R6 r0 after write B1", bus_b1, 32'd0);
        chk("R6 r0 after write B2", bus_b2, 32'd0);
        for (int r = 1; r < 8; r++) begin
          step(mk(5'b10101, 3'd0, 3'(r), 3'(8 - r), 17'd0), 1'b1, 1'b1, 1'b0, '0);
          #4 chk("R5 readback B2", bus_b2, 32'hA0000000 + r * 32'h1111);
          chk("R3 readback B1", bus_b1, 32'hA0000000 + (8 - r) * 32'h1111);
        end
        // R5: disabled write leaves contents alone
        step(mk(5'b00001, 3'd4, 3'd0, 3'd0, 17'd0), 1'b0, 1'b0, 1'b0, 32'h12345678);
        step(mk(5'b10101, 3'd0, 3'd4, 3'd0, 17'd0), 1'b0, 1'b1, 1'b0, '0);
        #4 chk("R5 no write when disabled", bus_b2, 32'hA0004444);
        // R2: store opcode takes B1 from destination field
        step(mk(5'b01101, 3'd5, 3'd2, 3'd3, 17'd0), 1'b1, 1'b1, 1'b0, '0);
        #4 chk("R2 store B1", bus_b1, 32'hA0005555);
        step(mk(5'b01100, 3'd5, 3'd2, 3'd3, 17'd0), 1'b1, 1'b1, 1'b0, '0);
        #4 chk("R2 load B1", bus_b1, 32'hA0003333);
        // R7: direct and indexed address, with wrap
        step({5'b01100, 1'b0, 3'd1, 3'd0, 20'hABCDE}, 1'b0, 1'b0, 1'b0, '0);
        #4 chk("R7 direct", mem_addr, 32'h000ABCDE);
        step(mk(5'b00001, 3'd6, 3'd0, 3'd0, 17'd0), 1'b0, 1'b0, 1'b1, 32'hFFFFFFF0);
        step({5'b01100, 1'b0, 3'd1, 3'd6, 20'h00020}, 1'b0, 1'b0, 1'b0, '0);
        #4 chk("R7 wrap", mem_addr, 32'h00000010);
        // Random traffic compared each cycle by the model
        for (int k = 0; k < 2000; k++) begin
          logic [31:0] ir;
          ir = $urandom;
          if (k % 5 == 0) ir[31:27] = 5'b01101;
          step(ir, 1'($urandom), 1'($urandom), 1'($urandom), $urandom);
        end
        // R8: reset in mid-run clears all entries
        step('0, 1'b0, 1'b0, 1'b0, '0);
        rst = 1'b1;
        step('0, 1'b0, 1'b0, 1'b0, '0);
        rst = 1'b0;
        for (int r = 1; r < 8; r++) begin
          step(mk(5'b10101, 3'd0, 3'(r), 3'd0, 17'd0), 1'b0, 1'b1, 1'b0, '0);
          #4 chk("R8 cleared after reset", bus_b2, 32'd0);
        end
        step('0, 1'b0, 1'b0, 1'b0, '0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule